// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block gates a bank of clock outputs for power saving. It has two gated groups, a CPU group and a PCI group, and it also passes a free-running PCI reference clock straight through. Each gated output runs only while two things allow it: its own enable bit in a small software-writable register bank, and the active-low stop pin of its group. A strap input decides whether the stop pins are used at all.

Every gated output has a capture flop that updates on the falling edge of the output's source clock. The enable can therefore change only while that clock is low, so a stopped output rests low and every high phase that is passed is a full one. A change on a stop pin is first sampled on a rising edge of the free-running reference clock, and then it reaches the output at the next falling edge of the output's own clock. A register write skips the reference-clock step and is picked up at the output's next falling edge.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst` is high, every gated output is held low. On the cycle that reset releases, all register enable bits read as 1, so every gated output runs when no stop pin is active.
- R2: A gated output runs only when its register enable bit is 1 and its group's stop permission is true. Otherwise it is held low.
- R3: With `mode_strap` = 1, both stop pins are ignored and treated as not stopping anything.
- R4: With `mode_strap` = 0 and `cpu_stop_n` = 0, every CPU output is low. The PCI outputs and the reference output keep running.
- R5: With `mode_strap` = 0 and `pci_stop_n` = 0, every PCI output is low. The CPU outputs and the reference output keep running.
- R6: A stopped output rests at logic 0, whether a pin or a register bit stopped it.
- R7: A stop-pin change has no effect before the next rising edge of `pci_ref_clk`. It takes effect at the first falling edge of the affected group's source clock after that rising edge.
- R8: Moving between running and stopped never produces a high pulse shorter than half a period of the source clock.
- R9: A write with `wr_en` = 1 to address 0 loads CPU enables from `wr_data` bits [3:0], with bit i controlling `cpu_clk_out[i]`. A write to address 1 loads PCI enables from bits [5:0], with bit i controlling `pci_clk_out[i]`. Writes to addresses 2 and 3 change nothing. A loaded bit takes effect at the output's next falling edge without waiting for the reference clock.
- R10: `pci_ref_out` follows `pci_ref_clk` at all times, whatever the pins, the strap and the registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Register-bank clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 6 | Register write data |
| mode_strap | input | 1 | 1 disables the stop pins |
| cpu_stop_n | input | 1 | Active-low stop request for the CPU group |
| pci_stop_n | input | 1 | Active-low stop request for the PCI group |
| cpu_clk_src | input | 1 | Source clock of the CPU group |
| pci_clk_src | input | 1 | Source clock of the PCI group |
| pci_ref_clk | input | 1 | Free-running PCI reference clock |
| cpu_clk_out | output | 4 | Gated CPU clocks |
| pci_clk_out | output | 6 | Gated PCI clocks |
| pci_ref_out | output | 1 | Ungated reference clock |

## Verification
The assertions check, on every relevant edge, the following:
- each capture flop loads exactly the AND of its register bit and its group's run flag;
- the run flags follow the strap and the pins one reference edge later;
- register writes, the absence of writes and the reset values behave as specified.

Only the bench's scenarios can show what appears on the clock outputs themselves. That covers full-width high pulses across every transition, outputs resting low when stopped, the neighbouring group and the reference clock still running, and the wait for the reference edge before a pin change shows up.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;
  parameter int unsigned CPU_OUTS    = 4;
  parameter int unsigned PCI_OUTS    = 6;
  parameter int unsigned REG_ADDR_W  = 2;
  parameter int unsigned CPU_EN_ADDR = 0;
  parameter int unsigned PCI_EN_ADDR = 1;
endpackage

// File: rtl/clkstop_regs.sv
`timescale 1ns/1ps
module clkstop_regs #(
  parameter int NUM_CPU = 4,
  parameter int NUM_PCI = 6,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_CPU-1:0] cpu_en,
  output logic [NUM_PCI-1:0] pci_en
);
  localparam logic [ADDR_W-1:0] CPU_A = ADDR_W'(clkstop_pkg::CPU_EN_ADDR);
  localparam logic [ADDR_W-1:0] PCI_A = ADDR_W'(clkstop_pkg::PCI_EN_ADDR);

  // Enable bank: all ones out of reset so every clock runs by default.
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_en <= '1;
      pci_en <= '1;
    end else if (wr_en) begin
      if (wr_addr == CPU_A) cpu_en <= wr_data[NUM_CPU-1:0];
      if (wr_addr == PCI_A) pci_en <= wr_data[NUM_PCI-1:0];
    end
  end
endmodule

// File: rtl/clkstop_pin_sync.sv
`timescale 1ns/1ps
module clkstop_pin_sync (
  input  logic ref_clk,
  input  logic rst,
  input  logic mode_strap,
  input  logic stop_n,
  output logic run
);
  // One rising reference edge before a pin change is seen by the gates.
  always_ff @(posedge ref_clk) begin
    if (rst) run <= 1'b1;
    else     run <= mode_strap | stop_n;
  end
endmodule

// File: rtl/clkstop_en_capture.sv
`timescale 1ns/1ps
module clkstop_en_capture #(
  parameter int WIDTH = 4
) (
  input  logic             clk_src,
  input  logic             rst,
  input  logic             run,
  input  logic [WIDTH-1:0] en_bits,
  output logic [WIDTH-1:0] gate_en
);
  // Each enable is captured on the falling edge, so it only moves while
  // the source clock is low and no high phase can be cut.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(negedge clk_src) begin
      if (rst) gate_en[i] <= 1'b0;
      else     gate_en[i] <= en_bits[i] & run;
    end
  end
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl #(
  parameter int NUM_CPU = clkstop_pkg::CPU_OUTS,
  parameter int NUM_PCI = clkstop_pkg::PCI_OUTS,
  parameter int ADDR_W  = clkstop_pkg::REG_ADDR_W,
  parameter int DATA_W  = (NUM_CPU > NUM_PCI) ? NUM_CPU : NUM_PCI
) (
  input  logic               cfg_clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               mode_strap,
  input  logic               cpu_stop_n,
  input  logic               pci_stop_n,
  input  logic               cpu_clk_src,
  input  logic               pci_clk_src,
  input  logic               pci_ref_clk,
  output logic [NUM_CPU-1:0] cpu_clk_out,
  output logic [NUM_PCI-1:0] pci_clk_out,
  output logic               pci_ref_out
);
  logic [NUM_CPU-1:0] cpu_en_reg;
  logic [NUM_PCI-1:0] pci_en_reg;
  logic               cpu_run;
  logic               pci_run;
  logic [NUM_CPU-1:0] cpu_gate_en;
  logic [NUM_PCI-1:0] pci_gate_en;

  clkstop_regs #(
    .NUM_CPU(NUM_CPU), .NUM_PCI(NUM_PCI), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(cfg_clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cpu_en(cpu_en_reg), .pci_en(pci_en_reg)
  );

  clkstop_pin_sync u_cpu_sync (
    .ref_clk(pci_ref_clk), .rst(rst), .mode_strap(mode_strap),
    .stop_n(cpu_stop_n), .run(cpu_run)
  );

  clkstop_pin_sync u_pci_sync (
    .ref_clk(pci_ref_clk), .rst(rst), .mode_strap(mode_strap),
    .stop_n(pci_stop_n), .run(pci_run)
  );

  clkstop_en_capture #(.WIDTH(NUM_CPU)) u_cpu_cap (
    .clk_src(cpu_clk_src), .rst(rst), .run(cpu_run),
    .en_bits(cpu_en_reg), .gate_en(cpu_gate_en)
  );

  clkstop_en_capture #(.WIDTH(NUM_PCI)) u_pci_cap (
    .clk_src(pci_clk_src), .rst(rst), .run(pci_run),
    .en_bits(pci_en_reg), .gate_en(pci_gate_en)
  );

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu_out
    assign cpu_clk_out[i] = cpu_clk_src & cpu_gate_en[i];
  end

  for (genvar i = 0; i < NUM_PCI; i++) begin : g_pci_out
    assign pci_clk_out[i] = pci_clk_src & pci_gate_en[i];
  end

  assign pci_ref_out = pci_ref_clk;
endmodule

// File: rtl/clkstop_ctrl_chk.sv
`timescale 1ns/1ps
module clkstop_ctrl_chk #(
  parameter int NUM_CPU = 4,
  parameter int NUM_PCI = 6,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 6
) (
  input logic               cfg_clk,
  input logic               rst,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               mode_strap,
  input logic               cpu_stop_n,
  input logic               pci_stop_n,
  input logic               cpu_clk_src,
  input logic               pci_clk_src,
  input logic               pci_ref_clk,
  input logic [NUM_CPU-1:0] cpu_en_reg,
  input logic [NUM_PCI-1:0] pci_en_reg,
  input logic               cpu_run,
  input logic               pci_run,
  input logic [NUM_CPU-1:0] cpu_gate_en,
  input logic [NUM_PCI-1:0] pci_gate_en
);
  localparam logic [ADDR_W-1:0] CPU_A = ADDR_W'(clkstop_pkg::CPU_EN_ADDR);
  localparam logic [ADDR_W-1:0] PCI_A = ADDR_W'(clkstop_pkg::PCI_EN_ADDR);

  assert_cpu_gate_and_R2: assert property (@(negedge cpu_clk_src) disable iff (rst)
    1'b1 |=> cpu_gate_en == $past(cpu_en_reg & {NUM_CPU{cpu_run}}));

  assert_pci_gate_and_R2: assert property (@(negedge pci_clk_src) disable iff (rst)
    1'b1 |=> pci_gate_en == $past(pci_en_reg & {NUM_PCI{pci_run}}));

  assert_cpu_ref_sample_R7: assert property (@(posedge pci_ref_clk) disable iff (rst)
    1'b1 |=> cpu_run == $past(mode_strap | cpu_stop_n));

  assert_pci_ref_sample_R7: assert property (@(posedge pci_ref_clk) disable iff (rst)
    1'b1 |=> pci_run == $past(mode_strap | pci_stop_n));

  assert_strap_overrides_R3: assert property (@(posedge pci_ref_clk) disable iff (rst)
    mode_strap |=> (cpu_run && pci_run));

  assert_cpu_write_R9: assert property (@(posedge cfg_clk) disable iff (rst)
    (wr_en && wr_addr == CPU_A) |=> cpu_en_reg == $past(wr_data[NUM_CPU-1:0]));

  assert_pci_write_R9: assert property (@(posedge cfg_clk) disable iff (rst)
    (wr_en && wr_addr == PCI_A) |=> pci_en_reg == $past(wr_data[NUM_PCI-1:0]));

  assert_no_write_hold_R9: assert property (@(posedge cfg_clk) disable iff (rst)
    !wr_en |=> ($stable(cpu_en_reg) && $stable(pci_en_reg)));

  assert_reset_ones_R1: assert property (@(posedge cfg_clk)
    $fell(rst) |-> (&cpu_en_reg && &pci_en_reg));
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(
  .NUM_CPU(NUM_CPU), .NUM_PCI(NUM_PCI), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .cfg_clk(cfg_clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .mode_strap(mode_strap), .cpu_stop_n(cpu_stop_n),
  .pci_stop_n(pci_stop_n), .cpu_clk_src(cpu_clk_src),
  .pci_clk_src(pci_clk_src), .pci_ref_clk(pci_ref_clk),
  .cpu_en_reg(cpu_en_reg), .pci_en_reg(pci_en_reg), .cpu_run(cpu_run),
  .pci_run(pci_run), .cpu_gate_en(cpu_gate_en), .pci_gate_en(pci_gate_en)
);

// File: tb/tb_clkstop_ctrl.sv
`timescale 1ns/1ps
module tb_clkstop_ctrl;
  localparam int NC = 4;
  localparam int NP = 6;
  localparam real CPU_HALF = 6.0;
  localparam real PCI_HALF = 15.0;

  logic cfg_clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [5:0] wr_data = '0;
  logic mode_strap = 1'b0, cpu_stop_n = 1'b1, pci_stop_n = 1'b1;
  logic cpu_clk = 1'b0, ref_clk = 1'b0;
  logic [NC-1:0] cpu_out;
  logic [NP-1:0] pci_out;
  logic ref_out;

  int n_checks = 0, n_fail = 0;
  int cpu_cnt [NC];
  int pci_cnt [NP];
  int ref_cnt = 0;
  real cpu_rise [NC];
  real pci_rise [NP];
  bit  cpu_seen [NC];
  bit  pci_seen [NP];

  clkstop_ctrl dut (
    .cfg_clk(cfg_clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_strap(mode_strap), .cpu_stop_n(cpu_stop_n),
    .pci_stop_n(pci_stop_n), .cpu_clk_src(cpu_clk), .pci_clk_src(ref_clk),
    .pci_ref_clk(ref_clk), .cpu_clk_out(cpu_out), .pci_clk_out(pci_out),
    .pci_ref_out(ref_out)
  );

  initial forever #10 cfg_clk = ~cfg_clk;
  initial forever #CPU_HALF cpu_clk = ~cpu_clk;
  initial begin #2; forever #PCI_HALF ref_clk = ~ref_clk; end

  task automatic check(input string tag, input int actual, input int expected);
    n_checks++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // R8: every high pulse on a gated output lasts a full half period.
  task automatic pulse_check(input string tag, input real width, input real want);
    n_checks++;
    if (width < want - 0.01 || width > want + 0.01) begin
      n_fail++;
      $display("FAIL R8 %s actual=%0.3f expected=%0.3f", tag, width, want);
    end
  endtask

  for (genvar g = 0; g < NC; g++) begin : g_cmon
    always @(posedge cpu_out[g]) begin cpu_cnt[g]++; cpu_rise[g] = $realtime; cpu_seen[g] = 1; end
    always @(negedge cpu_out[g]) if (cpu_seen[g]) pulse_check("cpu pulse", $realtime - cpu_rise[g], CPU_HALF);
  end
  for (genvar g = 0; g < NP; g++) begin : g_pmon
    always @(posedge pci_out[g]) begin pci_cnt[g]++; pci_rise[g] = $realtime; pci_seen[g] = 1; end
    always @(negedge pci_out[g]) if (pci_seen[g]) pulse_check("pci pulse", $realtime - pci_rise[g], PCI_HALF);
  end
  always @(posedge ref_out) ref_cnt++;

  task automatic clear_counts();
    for (int i = 0; i < NC; i++) cpu_cnt[i] = 0;
    for (int i = 0; i < NP; i++) pci_cnt[i] = 0;
    ref_cnt = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    @(negedge cfg_clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge cfg_clk);
    wr_en = 1'b0;
  endtask

  // Running: several rises in the window. Stopped: no rise and resting low (R6).
  task automatic check_out(input string tag, input int cnt, input logic lvl, input bit run);
    if (run) check(tag, (cnt >= 3) ? 1 : 0, 1);
    else begin
      check(tag, cnt, 0);
      check({tag, " R6 level"}, int'(lvl), 0);
    end
  endtask

  task automatic observe(input logic [NC-1:0] cm, input logic [NP-1:0] pm,
                         input string tag_c, input string tag_p);
    bit cr, pr;
    cr = mode_strap | cpu_stop_n;
    pr = mode_strap | pci_stop_n;
    #200;
    clear_counts();
    #300;
    for (int i = 0; i < NC; i++) check_out(tag_c, cpu_cnt[i], cpu_out[i], cm[i] & cr);
    for (int i = 0; i < NP; i++) check_out(tag_p, pci_cnt[i], pci_out[i], pm[i] & pr);
    check("R10 ref runs", (ref_cnt >= 5) ? 1 : 0, 1);
  endtask

  initial begin
    for (int i = 0; i < NC; i++) begin cpu_cnt[i] = 0; cpu_seen[i] = 0; cpu_rise[i] = 0.0; end
    for (int i = 0; i < NP; i++) begin pci_cnt[i] = 0; pci_seen[i] = 0; pci_rise[i] = 0.0; end

    // R1: outputs low while in reset, reference still toggles.
    repeat (3) @(negedge cfg_clk);
    clear_counts();
    repeat (8) @(negedge cfg_clk);
    check("R1 cpu quiet in reset", cpu_cnt[0] + cpu_cnt[3], 0);
    check("R1 pci quiet in reset", pci_cnt[0] + pci_cnt[5], 0);
    check("R1 cpu low in reset", int'(cpu_out), 0);
    check("R10 ref in reset", (ref_cnt >= 3) ? 1 : 0, 1);
    rst = 1'b0;
    observe('1, '1, "R1 cpu default run", "R1 pci default run");

    // Sweep: strap x two pins x register patterns (R2..R6).
    for (int md = 0; md < 2; md++)
      for (int cs = 0; cs < 2; cs++)
        for (int ps = 0; ps < 2; ps++)
          for (int m = 0; m < 16; m++) begin
            logic [5:0] pm;
            string tc, tp;
            pm = 6'((m * 5 + 3) % 64);
            wr(2'd0, {2'b00, 4'(m)});
            wr(2'd1, pm);
            @(negedge cfg_clk);
            mode_strap = md[0]; cpu_stop_n = cs[0]; pci_stop_n = ps[0];
            tc = (md == 1) ? "R3 cpu" : (cs == 0) ? "R4 cpu" : "R2 cpu";
            tp = (md == 1) ? "R3 pci" : (ps == 0) ? "R5 pci" : "R2 pci";
            observe(4'(m), pm, tc, tp);
          end

    // R9: unused addresses change nothing.
    mode_strap = 1'b0; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    wr(2'd0, 6'h3f);
    wr(2'd1, 6'h3f);
    wr(2'd2, 6'h00);
    wr(2'd3, 6'h00);
    observe('1, '1, "R9 cpu after addr2/3", "R9 pci after addr2/3");
    wr(2'd0, 6'h05);
    wr(2'd1, 6'h21);
    observe(4'h5, 6'h21, "R9 cpu bits", "R9 pci bits");
    wr(2'd0, 6'h3f);
    wr(2'd1, 6'h3f);

    // R7: pin change is invisible until the next reference rising edge.
    @(posedge ref_clk); #1;
    cpu_stop_n = 1'b0;
    clear_counts();
    #27;
    check("R7 cpu still runs before ref edge", (cpu_cnt[0] >= 1) ? 1 : 0, 1);
    @(posedge ref_clk); #13;
    clear_counts();
    #60;
    check("R7 cpu stopped after ref+fall", cpu_cnt[0] + cpu_cnt[1] + cpu_cnt[2] + cpu_cnt[3], 0);
    check("R4 pci unaffected", (pci_cnt[2] >= 1) ? 1 : 0, 1);
    @(posedge ref_clk); #1;
    cpu_stop_n = 1'b1;
    clear_counts();
    #27;
    check("R7 cpu still stopped before ref edge", cpu_cnt[0], 0);
    @(posedge ref_clk); #13;
    clear_counts();
    #60;
    check("R7 cpu restarts", (cpu_cnt[0] >= 3) ? 1 : 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule